// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and a 24-line parallel pixel bus. Each cycle it takes one 24-bit RGB pixel with red in bits 23:16, green in 15:8 and blue in 7:0, plus active-high horizontal sync, vertical sync and data-enable strobes. It reorders the three colour channels and packs them onto the data lines in one of several fixed layouts. It then drives the sync and enable lines, each with its own polarity, launch edge and suppression setting. It also drives an optionally inverted copy of the pixel clock for the panel.

All settings live in one control word, written and read over a small 32-bit register bus. Bit 0 of the control word is the master enable. A written value is held in a shadow copy and moves into the working copy only at the start of a vertical sync pulse, so a frame is never formatted with mixed settings. The exception is when the block is off, or is being switched off: then the new value moves across at once. Reads from register address 0 return the control word. Reads from any other address return a fixed identification value.

Top module: `rgb_out_fmt`

## Requirements
- R1: After reset the control word reads as zero, every data line and the hsync, vsync and data-enable outputs are 0, and the panel clock output `disp_clk` is held low.
- R2: Writing address 0 stores bits 16:0 of the write data. Reading address 0 returns that value with bits 31:17 as zero. Reading any non-zero address returns 32'h00647069.
- R3: Bits 15:14 select the channel order that feeds the packer, naming the channels in first, second, third slot: 0 = R,G,B; 1 = B,G,R; 2 = G,R,B; 3 = B,R,G.
- R4: Bits 13:11 select the packing. With first/second/third slot channels A, B, C, and reductions that keep the top bits: 0 and 7 drive all 24 lines to 0; 1 = {8'b0, A[7:3], B[7:2], C[7:3]}; 2 = {3'b0, A[7:3], 2'b0, B[7:2], 3'b0, C[7:3]}; 3 = {2'b0, A[7:3], 3'b0, B[7:2], 2'b0, C[7:3], 1'b0}; 4 = {6'b0, A[7:2], B[7:2], C[7:2]}; 5 = {2'b0, A[7:2], 2'b0, B[7:2], 2'b0, C[7:2]}; 6 = {A, B, C}.
- R5: An input pixel and its strobes sampled at a rising clock edge appear together on the outputs after that edge, which is one cycle of latency, and not before it.
- R6: Bit 10 inverts `disp_clk` relative to the internal clock. Bits 9, 8 and 7 invert the hsync, vsync and data-enable outputs.
- R7: Bits 6, 5 and 4 make hsync, vsync and data-enable launch on the falling clock edge, half a cycle after the rising-edge launch.
- R8: Bits 3, 2 and 1 hold hsync, vsync and data-enable at their inactive level, which is 1 when that signal's invert bit is set and 0 otherwise. Pixel data keeps flowing.
- R9: Bit 16 set routes the data-enable input to the data-enable output. Bit 16 clear routes the OR of the hsync and vsync inputs to it instead.
- R10: While the working enable is 0, all outputs including `disp_clk` are 0. When the enable goes from 0 to 1 the pipeline starts cleared: in the first cycle data is 0 and every control line is at its inactive level.
- R11: While the block is on, a written control value takes effect at the rising edge after the one where vsync is first seen high. A write that lands in the same cycle as that vsync rise waits for the next vsync rise. A write with bit 0 clear, or any write made while the block is off, takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data, combinational from address |
| pix_in | input | 3*CHAN_W | Input pixel {R, G, B} |
| hs_in | input | 1 | Horizontal sync in, active high |
| vs_in | input | 1 | Vertical sync in, active high |
| de_in | input | 1 | Data enable in, active high |
| pix_out | output | 3*CHAN_W | Packed data lines |
| hs_out | output | 1 | Horizontal sync out |
| vs_out | output | 1 | Vertical sync out |
| de_out | output | 1 | Data enable out |
| disp_clk | output | 1 | Panel clock, optionally inverted |

## Verification
A control write and the start of vertical sync can fall in the same rising edge. In that case the write fills the shadow copy while the working copy loads the shadow's old contents. The bench provokes this by raising the write strobe and vsync together. It then requires the old packing to hold for the following pixel, and the new packing to appear only after a second vsync rise. The bench also checks the two launch edges within a single cycle: it samples shortly after the rising edge and again after the falling edge. A falling-launched signal must show the old value at the first sample and the new value at the second, while a rising-launched signal shows the new value at both.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

   localparam int CTRL_W = 17;

   // Working control word layout; bit positions are visible to software.
   // Three-bit groups are indexed 2 = hsync, 1 = vsync, 0 = data enable.
   typedef struct packed {
      logic       oe_mode;   // 16
      logic [1:0] order;     // 15:14
      logic [2:0] fmt;       // 13:11
      logic       clk_inv;   // 10
      logic [2:0] inv;       // 9:7
      logic [2:0] fall;      // 6:4
      logic [2:0] dis;       // 3:1
      logic       en;        // 0
   } fmt_ctrl_t;

   typedef enum logic [1:0] {
      ORD_RGB = 2'd0,
      ORD_BGR = 2'd1,
      ORD_GRB = 2'd2,
      ORD_BRG = 2'd3
   } chan_order_e;

   typedef enum logic [2:0] {
      PK_ZERO   = 3'd0,
      PK_565_LO = 3'd1,
      PK_565_P3 = 3'd2,
      PK_565_P2 = 3'd3,
      PK_666_LO = 3'd4,
      PK_666_LN = 3'd5,
      PK_888    = 3'd6,
      PK_RSVD   = 3'd7
   } pack_fmt_e;

endpackage

// File: rtl/rgbfmt_ctrl.sv
module rgbfmt_ctrl
   import rgbfmt_pkg::*;
#(
   parameter int              ADDR_W   = 4,
   parameter int              BUS_W    = 32,
   parameter logic [BUS_W-1:0] ID_VALUE = 32'h0064_7069
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              vs_start,
   output fmt_ctrl_t         active
);

   localparam int PAD_W = BUS_W - CTRL_W;

   if (BUS_W < CTRL_W) begin : g_bus_check
      $error("BUS_W must hold the control word");
   end
   if (ADDR_W < 1) begin : g_addr_check
      $error("ADDR_W must be at least 1");
   end

   fmt_ctrl_t shadow;
   logic      sel_ctrl;
   logic      load;

   assign sel_ctrl = (reg_addr == '0);
   assign load     = vs_start | ~active.en | ~shadow.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (reg_wr && sel_ctrl) begin
         shadow <= fmt_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= '0;
      end else if (load) begin
         active <= shadow;
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign reg_rdata = sel_ctrl ? {{PAD_W{1'b0}}, shadow} : ID_VALUE;
   end else begin : g_nopad
      assign reg_rdata = sel_ctrl ? BUS_W'(shadow) : ID_VALUE;
   end

   // R11: while running, settings hold until a vsync start
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active.en && shadow.en && !vs_start) |=> $stable(active));

endmodule

// File: rtl/rgbfmt_order.sv
module rgbfmt_order
   import rgbfmt_pkg::*;
#(
   parameter int CHAN_W = 8
) (
   input  logic [3*CHAN_W-1:0] pix,
   input  logic [1:0]          order,
   output logic [CHAN_W-1:0]   slot_a,
   output logic [CHAN_W-1:0]   slot_b,
   output logic [CHAN_W-1:0]   slot_c
);

   logic [CHAN_W-1:0] red, grn, blu;

   assign red = pix[3*CHAN_W-1 -: CHAN_W];
   assign grn = pix[2*CHAN_W-1 -: CHAN_W];
   assign blu = pix[CHAN_W-1   -: CHAN_W];

   always_comb begin
      unique case (chan_order_e'(order))
         ORD_BGR: begin slot_a = blu; slot_b = grn; slot_c = red; end
         ORD_GRB: begin slot_a = grn; slot_b = red; slot_c = blu; end
         ORD_BRG: begin slot_a = blu; slot_b = red; slot_c = grn; end
         default: begin slot_a = red; slot_b = grn; slot_c = blu; end
      endcase
   end

endmodule

// File: rtl/rgbfmt_pack.sv
module rgbfmt_pack
   import rgbfmt_pkg::*;
#(
   parameter int CHAN_W = 8
) (
   input  logic [CHAN_W-1:0]   slot_a,
   input  logic [CHAN_W-1:0]   slot_b,
   input  logic [CHAN_W-1:0]   slot_c,
   input  logic [2:0]          fmt,
   output logic [3*CHAN_W-1:0] lines
);

   localparam int LINES_W = 3 * CHAN_W;

   if (CHAN_W != 8) begin : g_chan_check
      $error("packing layouts are defined for 8-bit channels");
   end

   logic [4:0] a5, c5;
   logic [5:0] a6, b6, c6;

   assign a5 = slot_a[CHAN_W-1 -: 5];
   assign c5 = slot_c[CHAN_W-1 -: 5];
   assign a6 = slot_a[CHAN_W-1 -: 6];
   assign b6 = slot_b[CHAN_W-1 -: 6];
   assign c6 = slot_c[CHAN_W-1 -: 6];

   always_comb begin
      unique case (pack_fmt_e'(fmt))
         PK_565_LO: lines = {8'b0, a5, b6, c5};
         PK_565_P3: lines = {3'b0, a5, 2'b0, b6, 3'b0, c5};
         PK_565_P2: lines = {2'b0, a5, 3'b0, b6, 2'b0, c5, 1'b0};
         PK_666_LO: lines = {6'b0, a6, b6, c6};
         PK_666_LN: lines = {2'b0, a6, 2'b0, b6, 2'b0, c6};
         PK_888:    lines = {slot_a, slot_b, slot_c};
         default:   lines = '0;
      endcase
   end

   // R4: any nonzero packing leaves at least the top two lines clear
   //     unless the full-width layout is chosen
   always_comb begin
      assert_top_clear_R4: assert (fmt == 3'd6 || lines[LINES_W-1 -: 2] == 2'b00);
   end

endmodule

// File: rtl/rgbfmt_sync_lane.sv
module rgbfmt_sync_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sig_in,
   input  logic inv,
   input  logic fall,
   input  logic dis,
   output logic sig_out
);

   logic pos_q;
   logic neg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= 1'b0;
      end else if (!en) begin
         pos_q <= 1'b0;
      end else begin
         pos_q <= sig_in & ~dis;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q <= 1'b0;
      end else if (!en) begin
         neg_q <= 1'b0;
      end else begin
         neg_q <= pos_q;
      end
   end

   assign sig_out = en & ((fall ? neg_q : pos_q) ^ inv);

   // R8: a suppressed line sits at its inactive level
   assert_dis_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dis && $past(en) && $past(dis)) |-> (sig_out == inv));

   // R10: first cycle after enabling shows an inactive line
   assert_fresh_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (sig_out == inv));

endmodule

// File: rtl/rgb_out_fmt.sv
module rgb_out_fmt
   import rgbfmt_pkg::*;
#(
   parameter int              ADDR_W   = 4,
   parameter int              BUS_W    = 32,
   parameter int              CHAN_W   = 8,
   parameter logic [BUS_W-1:0] ID_VALUE = 32'h0064_7069
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   input  logic [3*CHAN_W-1:0] pix_in,
   input  logic                hs_in,
   input  logic                vs_in,
   input  logic                de_in,
   output logic [3*CHAN_W-1:0] pix_out,
   output logic                hs_out,
   output logic                vs_out,
   output logic                de_out,
   output logic                disp_clk
);

   localparam int PIX_W   = 3 * CHAN_W;
   localparam int N_LANES = 3;

   fmt_ctrl_t         act;
   logic              vs_prev;
   logic              vs_start;
   logic [CHAN_W-1:0] sa, sb, sc;
   logic [PIX_W-1:0]  packed_px;
   logic [PIX_W-1:0]  data_q;
   logic              de_src;
   logic [N_LANES-1:0] lane_in;
   logic [N_LANES-1:0] lane_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_prev <= 1'b0;
      else        vs_prev <= vs_in;
   end
   assign vs_start = vs_in & ~vs_prev;

   rgbfmt_ctrl #(
      .ADDR_W  (ADDR_W),
      .BUS_W   (BUS_W),
      .ID_VALUE(ID_VALUE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .vs_start (vs_start),
      .active   (act)
   );

   rgbfmt_order #(.CHAN_W(CHAN_W)) u_order (
      .pix   (pix_in),
      .order (act.order),
      .slot_a(sa),
      .slot_b(sb),
      .slot_c(sc)
   );

   rgbfmt_pack #(.CHAN_W(CHAN_W)) u_pack (
      .slot_a(sa),
      .slot_b(sb),
      .slot_c(sc),
      .fmt   (act.fmt),
      .lines (packed_px)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (!act.en) data_q <= '0;
      else              data_q <= packed_px;
   end

   assign pix_out = act.en ? data_q : '0;

   assign de_src  = act.oe_mode ? de_in : (hs_in | vs_in);
   assign lane_in = {hs_in, vs_in, de_src};

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      rgbfmt_sync_lane u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (act.en),
         .sig_in (lane_in[i]),
         .inv    (act.inv[i]),
         .fall   (act.fall[i]),
         .dis    (act.dis[i]),
         .sig_out(lane_out[i])
      );
   end

   assign hs_out   = lane_out[2];
   assign vs_out   = lane_out[1];
   assign de_out   = lane_out[0];
   assign disp_clk = act.en & (clk ^ act.clk_inv);

   // R5/R4: full-width, native order passes the pixel one cycle later
   assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act.en && $past(act.en) && $past(act.fmt) == 3'd6 && $past(act.order) == 2'd0)
      |-> (pix_out == $past(pix_in)));

   // R4: blank layouts drive zero
   assert_blank_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act.en) && ($past(act.fmt) == 3'd0 || $past(act.fmt) == 3'd7))
      |-> (pix_out == '0));

   // R10: pipeline starts cleared on enable
   assert_clear_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act.en) |-> (pix_out == '0));

endmodule

// File: tb/rgb_out_fmt_test.sv
module rgb_out_fmt_test;

   localparam logic [31:0] ID = 32'h0064_7069;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [23:0] pix_in = '0;
   logic        hs_in = 1'b0;
   logic        vs_in = 1'b0;
   logic        de_in = 1'b0;
   logic [23:0] pix_out;
   logic        hs_out, vs_out, de_out, disp_clk;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   rgb_out_fmt uut (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
      .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out),
      .disp_clk(disp_clk)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [31:0] v);
      reg_addr  = '0;
      reg_wdata = v;
      reg_wr    = 1'b1;
      tick();
      reg_wr    = 1'b0;
   endtask

   task automatic apply(logic [31:0] v);
      wr(v);
      vs_in = 1'b1;
      tick();
      vs_in = 1'b0;
   endtask

   function automatic logic [31:0] cw(int order, int fmt, bit mode);
      return (32'(mode) << 16) | (32'(order) << 14) | (32'(fmt) << 11) | 32'h1;
   endfunction

   function automatic logic [23:0] ref_pack(int order, int fmt, logic [23:0] p);
      int r, g, b, a, m, c;
      r = int'(p) / 65536;
      g = (int'(p) / 256) % 256;
      b = int'(p) % 256;
      case (order)
         1: begin a = b; m = g; c = r; end
         2: begin a = g; m = r; c = b; end
         3: begin a = b; m = r; c = g; end
         default: begin a = r; m = g; c = b; end
      endcase
      case (fmt)
         1: return 24'((a / 8) * 2048 + (m / 4) * 32 + c / 8);
         2: return 24'((a / 8) * 65536 + (m / 4) * 256 + c / 8);
         3: return 24'((a / 8) * 131072 + (m / 4) * 256 + (c / 8) * 2);
         4: return 24'((a / 4) * 4096 + (m / 4) * 64 + c / 4);
         5: return 24'((a / 4) * 65536 + (m / 4) * 256 + c / 4);
         6: return 24'(a * 65536 + m * 256 + c);
         default: return 24'd0;
      endcase
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [23:0] p;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 ctrl", reg_rdata, 32'h0);
      chk("R1 data", {8'h0, pix_out}, 32'h0);
      chk("R1 sync", {29'h0, hs_out, vs_out, de_out}, 32'h0);
      chk("R1 clk", {31'h0, disp_clk}, 32'h0);

      // R2 ID readback at several addresses
      for (int a = 1; a < 16; a += 5) begin
         reg_addr = 4'(a);
         #1;
         chk("R2 id", reg_rdata, ID);
      end
      reg_addr = '0;
      wr(32'hFFFF_FFFE);
      chk("R2 readback", reg_rdata, 32'h0001_FFFE);
      wr(32'h0);
      tick();

      // R3 / R4 sweep over every order and format
      for (int o = 0; o < 4; o++) begin
         for (int f = 0; f < 8; f++) begin
            apply(cw(o, f, 1'b1));
            for (int k = 0; k < 3; k++) begin
               p = {8'(o * 37 + k * 91 + 5), 8'(f * 53 + k * 29 + 200), 8'(o * 17 + f * 11 + k * 77)};
               pix_in = p;
               tick();
               chk($sformatf("R3 R4 order %0d fmt %0d", o, f), {8'h0, pix_out},
                   {8'h0, ref_pack(o, f, p)});
            end
         end
      end

      // R5 latency and alignment
      apply(cw(0, 6, 1'b1));
      hs_in = 0; de_in = 0; pix_in = 24'h000000;
      tick();
      hs_in = 1; de_in = 1; vs_in = 1; pix_in = 24'hC0FFEE;
      #1;
      chk("R5 not early", {29'h0, hs_out, vs_out, de_out}, 32'h0);
      tick();
      chk("R5 data", {8'h0, pix_out}, 32'h00C0FFEE);
      chk("R5 sync", {29'h0, hs_out, vs_out, de_out}, 32'h7);
      hs_in = 0; vs_in = 0; de_in = 0;
      tick();

      // R6 polarity
      apply(cw(0, 6, 1'b1) | 32'h0000_0780);
      tick();
      chk("R6 inverted idle", {29'h0, hs_out, vs_out, de_out}, 32'h7);
      chk("R6 clk high phase", {31'h0, disp_clk}, 32'h0);
      #5;
      chk("R6 clk low phase", {31'h0, disp_clk}, 32'h1);
      hs_in = 1; de_in = 1;
      tick();
      chk("R6 inverted active", {29'h0, hs_out, vs_out, de_out}, 32'h2);
      hs_in = 0; de_in = 0;
      apply(cw(0, 6, 1'b1));
      tick();
      chk("R6 clk plain", {31'h0, disp_clk}, 32'h1);

      // R7 falling-edge launch on hsync only
      apply(cw(0, 6, 1'b1) | 32'h0000_0040);
      tick();
      hs_in = 1; de_in = 1;
      tick();
      chk("R7 fall lags", {31'h0, hs_out}, 32'h0);
      chk("R7 rise on time", {31'h0, de_out}, 32'h1);
      #5;
      chk("R7 fall after negedge", {31'h0, hs_out}, 32'h1);
      hs_in = 0; de_in = 0;
      tick();

      // R8 disables with hsync inverted
      apply(cw(0, 6, 1'b1) | 32'h0000_020E);
      hs_in = 1; vs_in = 1; de_in = 1; pix_in = 24'h123456;
      tick();
      chk("R8 disabled levels", {29'h0, hs_out, vs_out, de_out}, 32'h4);
      chk("R8 data flows", {8'h0, pix_out}, 32'h00123456);
      hs_in = 0; vs_in = 0; de_in = 0;
      tick();

      // R9 data-enable source selection
      apply(cw(0, 6, 1'b0));
      hs_in = 1; de_in = 0;
      tick();
      chk("R9 sync on enable line", {31'h0, de_out}, 32'h1);
      hs_in = 0; de_in = 1;
      tick();
      chk("R9 enable input ignored", {31'h0, de_out}, 32'h0);
      de_in = 0;

      // R11 staged update, including write coinciding with vsync rise
      apply(cw(0, 6, 1'b1));
      wr(cw(0, 1, 1'b1));
      pix_in = 24'hA1B2C3;
      tick();
      chk("R11 held mid frame", {8'h0, pix_out}, {8'h0, ref_pack(0, 6, 24'hA1B2C3)});
      vs_in = 1;
      tick();
      vs_in = 0;
      tick();
      chk("R11 applied at vsync", {8'h0, pix_out}, {8'h0, ref_pack(0, 1, 24'hA1B2C3)});
      reg_wdata = cw(0, 4, 1'b1); reg_wr = 1; vs_in = 1;
      tick();
      reg_wr = 0; vs_in = 0;
      tick();
      chk("R11 same-cycle write waits", {8'h0, pix_out}, {8'h0, ref_pack(0, 1, 24'hA1B2C3)});
      vs_in = 1;
      tick();
      vs_in = 0;
      tick();
      chk("R11 next vsync applies", {8'h0, pix_out}, {8'h0, ref_pack(0, 4, 24'hA1B2C3)});

      // R10 / R11 disable takes effect without vsync
      apply(cw(0, 6, 1'b1));
      hs_in = 1; de_in = 1; pix_in = 24'h5A5A5A;
      wr(32'h0);
      chk("R11 disable pending one edge", {8'h0, pix_out}, 32'h005A5A5A);
      tick();
      chk("R10 idle data", {8'h0, pix_out}, 32'h0);
      chk("R10 idle sync", {29'h0, hs_out, vs_out, de_out}, 32'h0);
      chk("R10 idle clk high", {31'h0, disp_clk}, 32'h0);
      #5;
      chk("R10 idle clk low", {31'h0, disp_clk}, 32'h0);

      // R10 enable restarts from a cleared pipeline
      wr(cw(0, 6, 1'b1));
      chk("R10 still off", {8'h0, pix_out}, 32'h0);
      tick();
      chk("R10 cleared data", {8'h0, pix_out}, 32'h0);
      chk("R10 cleared sync", {29'h0, hs_out, vs_out, de_out}, 32'h0);
      tick();
      chk("R10 running data", {8'h0, pix_out}, 32'h005A5A5A);
      chk("R10 running sync", {29'h0, hs_out, vs_out, de_out}, 32'h5);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule